// File: doc/BRIEF.md
# Vector Register Writeback Merge

This block sits at the point where a freshly computed vector register group is written back. Every element of the group gets one of three values: the new result, the value the destination already held, or a fill of all ones. The choice for an element depends on where it lies relative to the active vector length, on its mask bit when the operation is masked, and on two independent policy bits. One policy bit covers elements past the length and the other covers masked-off elements. The fill value is always all ones and never zeros.

The element width is chosen per transfer from 8, 16, 32 or 64 bits, and element boundaries inside the data word follow it. The merge itself is combinational. It feeds a single register stage whose output is a valid/ready stream. A transfer is accepted on a rising edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output data holds still and no new transfer is accepted.

Top module: `vmrg_top`

## Requirements
- R1: `elem_w` selects the element width: code 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. Element i occupies bits [i*W +: W] of the data word, so element 0 sits at the least significant end, and its mask bit is `mask_bits[i]`.
- R2: In a masked operation (`is_masked`=1), an element with index below `vl` whose mask bit is 1 receives the new result.
- R3: An element with index at or above `vl` keeps its old destination value when `tail_fill`=0.
- R4: An element with index at or above `vl` becomes all ones when `tail_fill`=1.
- R5: In an unmasked operation (`is_masked`=0), every element below `vl` receives the new result, whatever its mask bit.
- R6: In a masked operation, an element below `vl` whose mask bit is 0 keeps its old value when `mask_fill`=0.
- R7: In a masked operation, an element below `vl` whose mask bit is 0 becomes all ones when `mask_fill`=1.
- R8: For an element at or above `vl`, the tail policy decides the outcome and its mask bit plays no part.
- R9: When `vl` is at or above the number of elements in the word, no element is treated as tail.
- R10: A transfer accepted on a rising edge appears on `out_data`, with `out_valid` high, right after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold.
- R11: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transfer valid |
| in_ready | output | 1 | Input transfer accepted when high |
| new_data | input | DW | Freshly computed result word |
| old_data | input | DW | Previous destination word |
| mask_bits | input | DW/8 | Mask bit per element, bit i for element i |
| vl | input | $clog2(DW/8+1) | Active vector length in elements |
| elem_w | input | 2 | Element width code |
| is_masked | input | 1 | Operation honours the mask |
| tail_fill | input | 1 | 1: tail elements become all ones; 0: keep old |
| mask_fill | input | 1 | 1: masked-off elements become all ones; 0: keep old |
| out_valid | output | 1 | Merged word valid |
| out_ready | input | 1 | Downstream accepts merged word |
| out_data | output | DW | Merged register word |

## Verification
A wrong classification shows up as a whole element, not a partial one, holding the wrong one of new, old or all-ones. The fault is visible one cycle after the transfer is accepted. A wrong element-width decode spreads the error across element boundaries. It appears as mismatches on some elements only for the affected width codes, so the sweep crosses every width code with lengths from zero to past the element count. A faulty output stage shows as data changing during a stall, or as a transfer lost at the first cycle of back-pressure.

// File: rtl/vmrg_pkg.sv
package vmrg_pkg;
  typedef enum logic [1:0] {
    SEL_NEW  = 2'd0,
    SEL_OLD  = 2'd1,
    SEL_ONES = 2'd2
  } sel_t;

  typedef enum logic [1:0] {
    EW8  = 2'd0,
    EW16 = 2'd1,
    EW32 = 2'd2,
    EW64 = 2'd3
  } ew_t;
endpackage

// File: rtl/vmrg_classify.sv
module vmrg_classify
  import vmrg_pkg::*;
#(
  parameter int DW = 128,
  localparam int NB  = DW / 8,
  localparam int IW  = $clog2(NB),
  localparam int VLW = $clog2(NB + 1)
) (
  input  logic [NB-1:0]  mask_bits,
  input  logic [VLW-1:0] vl,
  input  ew_t            ew,
  input  logic           is_masked,
  input  logic           tail_fill,
  input  logic           mask_fill,
  output sel_t           sel [NB]
);
  // Every byte works out which element owns it; bytes of one element agree.
  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [IW-1:0]  idx;
    logic [VLW-1:0] idx_w;
    logic           is_tail;
    logic           is_off;
    always_comb begin
      idx     = IW'(b) >> ew;
      idx_w   = VLW'(idx);
      is_tail = idx_w >= vl;
      is_off  = is_masked && !mask_bits[idx];
      if (is_tail)      sel[b] = tail_fill ? SEL_ONES : SEL_OLD;  // tail wins (R8)
      else if (is_off)  sel[b] = mask_fill ? SEL_ONES : SEL_OLD;
      else              sel[b] = SEL_NEW;
    end
  end
endmodule

// File: rtl/vmrg_lane_mux.sv
module vmrg_lane_mux
  import vmrg_pkg::*;
#(
  parameter int DW = 128,
  localparam int NB = DW / 8
) (
  input  logic [DW-1:0] new_data,
  input  logic [DW-1:0] old_data,
  input  sel_t          sel [NB],
  output logic [DW-1:0] merged
);
  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_comb begin
      unique case (sel[b])
        SEL_NEW:  merged[b*8 +: 8] = new_data[b*8 +: 8];
        SEL_OLD:  merged[b*8 +: 8] = old_data[b*8 +: 8];
        default:  merged[b*8 +: 8] = 8'hFF;
      endcase
    end
  end
endmodule

// File: rtl/vmrg_out_stage.sv
module vmrg_out_stage #(
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_valid && in_ready) out_data <= in_data;
    end
  end

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid) |-> in_ready);
endmodule

// File: rtl/vmrg_top.sv
module vmrg_top
  import vmrg_pkg::*;
#(
  parameter int DW = 128,
  localparam int NB  = DW / 8,
  localparam int VLW = $clog2(NB + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [DW-1:0]  new_data,
  input  logic [DW-1:0]  old_data,
  input  logic [NB-1:0]  mask_bits,
  input  logic [VLW-1:0] vl,
  input  logic [1:0]     elem_w,
  input  logic           is_masked,
  input  logic           tail_fill,
  input  logic           mask_fill,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_data
);
  sel_t          sel [NB];
  logic [DW-1:0] merged;
  ew_t           ew;

  assign ew = ew_t'(elem_w);

  vmrg_classify #(.DW(DW)) u_cls (
    .mask_bits (mask_bits),
    .vl        (vl),
    .ew        (ew),
    .is_masked (is_masked),
    .tail_fill (tail_fill),
    .mask_fill (mask_fill),
    .sel       (sel)
  );

  vmrg_lane_mux #(.DW(DW)) u_mux (
    .new_data (new_data),
    .old_data (old_data),
    .sel      (sel),
    .merged   (merged)
  );

  vmrg_out_stage #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (merged),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  p_vl0_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vl == '0 && !tail_fill) |-> (merged == old_data));

  p_vl0_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vl == '0 && tail_fill) |-> (merged == {DW{1'b1}}));

  p_full_body_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_masked && vl >= VLW'(NB)) |-> (merged == new_data));

  p_all_off_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_masked && mask_fill && tail_fill && mask_bits == '0) |-> (merged == {DW{1'b1}}));
endmodule

// File: tb/sim_vmrg_top.sv
`timescale 1ns/1ps
module sim_vmrg_top;
  localparam int DW  = 64;
  localparam int NB  = DW / 8;
  localparam int VLW = $clog2(NB + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [DW-1:0]  new_data = '0;
  logic [DW-1:0]  old_data = '0;
  logic [NB-1:0]  mask_bits = '0;
  logic [VLW-1:0] vl = '0;
  logic [1:0]     elem_w = '0;
  logic           is_masked = 1'b0;
  logic           tail_fill = 1'b0;
  logic           mask_fill = 1'b0;
  logic           out_valid;
  logic           out_ready = 1'b1;
  logic [DW-1:0]  out_data;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  vmrg_top #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .new_data(new_data), .old_data(old_data), .mask_bits(mask_bits), .vl(vl),
    .elem_w(elem_w), .is_masked(is_masked), .tail_fill(tail_fill),
    .mask_fill(mask_fill), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  // Expected word from the requirements, element by element (R1 layout).
  function automatic logic [DW-1:0] expect_word(output string tag);
    int ew = 8 << elem_w;
    int nel = NB >> elem_w;
    logic [DW-1:0] res = '0;
    logic [63:0] em = (ew == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << ew) - 64'd1);
    tag = (vl >= nel) ? "R9" : "R1";
    for (int e = 0; e < nel; e++) begin
      logic [63:0] nv = 64'(new_data >> (e * ew)) & em;
      logic [63:0] ov = 64'(old_data >> (e * ew)) & em;
      logic [63:0] v;
      if (e >= vl) begin
        v = tail_fill ? em : ov;
        if (is_masked && !mask_bits[e]) tag = "R8";
        else if (tag == "R1") tag = tail_fill ? "R4" : "R3";
      end else if (is_masked && !mask_bits[e]) begin
        v = mask_fill ? em : ov;
        if (tag == "R1") tag = mask_fill ? "R7" : "R6";
      end else begin
        v = nv;
        if (tag == "R1") tag = is_masked ? "R2" : "R5";
      end
      res = res | (DW'(v) << (e * ew));
    end
    return res;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (ew=%0d vl=%0d m=%0b ta=%0b ma=%0b mask=%b)",
               tag, act, exp, elem_w, vl, is_masked, tail_fill, mask_fill, mask_bits);
    end
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    string tag;
    logic [DW-1:0] exp;
    logic [DW-1:0] held;
    repeat (3) @(posedge clk);
    #1;
    check("R11", {63'd0, out_valid}, '0);
    check("R11", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R11", {63'd0, out_valid}, '0);

    // Sweep: every width code, lengths 0..9, both mask modes, both policies.
    for (int s = 0; s < 4; s++)
      for (int l = 0; l < 10; l++)
        for (int mm = 0; mm < 2; mm++)
          for (int pol = 0; pol < 4; pol++)
            for (int mp = 0; mp < 3; mp++) begin
              @(negedge clk);
              in_valid  = 1'b1;
              new_data  = {$urandom, $urandom};
              old_data  = {$urandom, $urandom};
              mask_bits = (mp == 0) ? 8'h00 : (mp == 1) ? 8'hA5 : NB'($urandom);
              vl        = VLW'(l);
              elem_w    = 2'(s);
              is_masked = mm[0];
              tail_fill = pol[0];
              mask_fill = pol[1];
              exp = expect_word(tag);
              @(posedge clk); #1;
              check("R10", {63'd0, out_valid}, 64'd1);
              check(tag, out_data, exp);
            end

    // Back-pressure (R10): stall holds data and refuses input.
    @(negedge clk);
    out_ready = 1'b0;
    held = out_data;
    new_data = 64'h0123_4567_89AB_CDEF;
    old_data = 64'hFEDC_BA98_7654_3210;
    vl = VLW'(NB); elem_w = 2'd0; is_masked = 1'b0;
    exp = new_data;
    #1;
    check("R10", {63'd0, in_ready}, '0);
    @(posedge clk); #1;
    check("R10", out_data, held);
    check("R10", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    check("R10", {63'd0, in_ready}, 64'd1);
    @(posedge clk); #1;
    check("R10", out_data, exp);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    check("R10", {63'd0, out_valid}, '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule